// File: doc/BRIEF.md
# Pipelined Fixed-Point Dot Product Engine

This block multiplies two vectors of signed 16-bit fixed-point numbers element by element and adds all the products. One vector carries connection weights and the other carries neuron activations. Both arrive as flat, parallel register banks. A single-cycle start strobe captures them. All element products are formed at once in one registered multiplier stage. A binary adder tree then reduces them, with a register at every level. The total leaves on a 32-bit output with a one-cycle valid pulse.

The default vector holds 26 elements: 25 receptive-field values and one bias slot. A bias needs no dedicated adder. The weight in the bias slot is set to 1.0 (raw value 1024), and the bias value goes in the matching activation slot. Results are in a 20-fractional-bit format and are not saturated. Operands are expected to be small enough that the true sum fits in 32 bits.

Each pipeline level only loads when the token for its operand set reaches it. As a result, the output holds its last result between pulses. Back-to-back strobes stream one result per cycle.

Top module: `dotprod_pipe`

## Requirements
- R1: While reset is high, and in the first cycle after it, valid_o is 0 and sum_o is 0.
- R2: Element i of each bank sits in bits [16i+15:16i]. It is read as a two's-complement value with 10 fractional bits. Element 25 is the bias slot and is handled like every other element.
- R3: Each weight/activation pair is multiplied as signed 16x16 into a full 32-bit product with 20 fractional bits. Extreme operands must multiply exactly, including -32768 x -32768 = 0x40000000.
- R4: sum_o equals the sum of all 26 products, taken modulo 2^32 (two's complement wrap, no saturation). In particular, all-zero weights give 0.
- R5: The strobe start_i is sampled at a clock edge. valid_o then rises after the 6th edge, counting that edge as the first, and stays high for exactly one cycle per strobe.
- R6: While valid_o is low, sum_o keeps the most recent result.
- R7: Strobes on consecutive cycles each produce their own result, in order, on consecutive cycles.
- R8: A weight of 1024 in slot 25 with activation b in that slot adds exactly b x 1024 to the 32-bit sum.
- R9: Every element position contributes, including positions that are left unpaired at an odd-sized tree level. A vector with a single nonzero pair at any position yields exactly that product.
- R10: While start_i is low, changes on the weight and activation banks have no effect on sum_o or valid_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle strobe that captures both banks |
| weights_i | input | 416 | Weight bank, 26 signed 16-bit elements |
| acts_i | input | 416 | Activation bank, 26 signed 16-bit elements |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| sum_o | output | 32 | Dot product, signed, 20 fractional bits |

## Verification
The bench builds the block with its default parameters: 26 elements of 16 bits, a 32-bit product and a five-level tree. With these values the tree shrinks 26, 13, 7, 4, 2, 1, so the pass-through path for unpaired operands is taken at two levels. A sweep that places a single nonzero pair at each of the 26 positions therefore reaches every path through the tree. The 16-bit operand range is small enough that the most negative values can be driven directly. This exposes exact product width and modulo-2^32 wrap of the total. Pseudo-random vectors, bias-slot vectors and back-to-back strobes cover streaming and output holding.

// File: rtl/dotprod_pkg.sv
package dotprod_pkg;

  // Number of operands remaining at tree level lvl for a vector of n elements.
  function automatic int lvl_cnt(input int n, input int lvl);
    return (n + (1 << lvl) - 1) >> lvl;
  endfunction

endpackage

// File: rtl/dp_valid_pipe.sv
module dp_valid_pipe #(
  parameter int LAT = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  output logic [LAT-1:0] stage_o
);

  logic [LAT-1:0] tok_q;

  always_ff @(posedge clk) begin
    if (rst) tok_q <= '0;
    else     tok_q <= {tok_q[LAT-2:0], start_i};
  end

  assign stage_o = tok_q;

endmodule

// File: rtl/dp_mult_bank.sv
module dp_mult_bank #(
  parameter int N_ELEM = 26,
  parameter int DW     = 16,
  parameter int PW     = 2 * DW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [N_ELEM*DW-1:0] wbank_i,
  input  logic [N_ELEM*DW-1:0] abank_i,
  output logic [N_ELEM*PW-1:0] prod_o
);

  for (genvar i = 0; i < N_ELEM; i++) begin : g_mul
    logic signed [DW-1:0] w_el, a_el;
    logic signed [PW-1:0] p_q;

    assign w_el = $signed(wbank_i[i*DW +: DW]);
    assign a_el = $signed(abank_i[i*DW +: DW]);

    always_ff @(posedge clk) begin
      if (rst)         p_q <= '0;
      else if (load_i) p_q <= PW'(w_el) * PW'(a_el);
    end

    assign prod_o[i*PW +: PW] = p_q;
  end

endmodule

// File: rtl/dp_adder_tree.sv
module dp_adder_tree
  import dotprod_pkg::*;
#(
  parameter int N_ELEM = 26,
  parameter int PW     = 32,
  parameter int GUARD  = 3,
  parameter int LEVELS = $clog2(N_ELEM)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LEVELS-1:0]    en_i,
  input  logic [N_ELEM*PW-1:0] prod_i,
  output logic [PW-1:0]        sum_o
);

  localparam int SW = PW + GUARD;

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int CNT = lvl_cnt(N_ELEM, l);
    localparam int W   = (l == LEVELS) ? PW : SW;

    logic signed [W-1:0] q [CNT];

    if (l == 0) begin : g_ext
      for (genvar i = 0; i < CNT; i++) begin : g_e
        assign q[i] = W'($signed(prod_i[i*PW +: PW]));
      end
    end else begin : g_add
      localparam int PCNT = lvl_cnt(N_ELEM, l - 1);
      for (genvar i = 0; i < CNT; i++) begin : g_n
        if (2 * i + 1 < PCNT) begin : g_pair
          always_ff @(posedge clk) begin
            if (rst)            q[i] <= '0;
            else if (en_i[l-1]) q[i] <= W'(g_lvl[l-1].q[2*i] + g_lvl[l-1].q[2*i+1]);
          end
        end else begin : g_pass
          always_ff @(posedge clk) begin
            if (rst)            q[i] <= '0;
            else if (en_i[l-1]) q[i] <= W'(g_lvl[l-1].q[2*i]);
          end
        end
      end
    end
  end

  assign sum_o = g_lvl[LEVELS].q[0];

endmodule

// File: rtl/dotprod_pipe.sv
module dotprod_pipe #(
  parameter int N_ELEM = 26,
  parameter int DW     = 16,
  parameter int PW     = 2 * DW,
  parameter int GUARD  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [N_ELEM*DW-1:0] weights_i,
  input  logic [N_ELEM*DW-1:0] acts_i,
  output logic                 valid_o,
  output logic [PW-1:0]        sum_o
);

  localparam int LEVELS = $clog2(N_ELEM);
  localparam int LAT    = LEVELS + 1;

  logic [LAT-1:0]       tok;
  logic [N_ELEM*PW-1:0] prod;

  dp_valid_pipe #(.LAT(LAT)) vpipe_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .stage_o (tok)
  );

  dp_mult_bank #(.N_ELEM(N_ELEM), .DW(DW), .PW(PW)) mbank_i (
    .clk     (clk),
    .rst     (rst),
    .load_i  (start_i),
    .wbank_i (weights_i),
    .abank_i (acts_i),
    .prod_o  (prod)
  );

  dp_adder_tree #(.N_ELEM(N_ELEM), .PW(PW), .GUARD(GUARD), .LEVELS(LEVELS)) tree_i (
    .clk    (clk),
    .rst    (rst),
    .en_i   (tok[LAT-2:0]),
    .prod_i (prod),
    .sum_o  (sum_o)
  );

  assign valid_o = tok[LAT-1];

endmodule

// File: rtl/dotprod_pipe_chk.sv
module dotprod_pipe_chk #(
  parameter int N_ELEM = 26,
  parameter int DW     = 16,
  parameter int PW     = 32,
  parameter int LAT    = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start_i,
  input logic [N_ELEM*DW-1:0] weights_i,
  input logic                 valid_o,
  input logic [PW-1:0]        sum_o
);

  int unsigned since_rst;

  always_ff @(posedge clk) begin
    if (rst)                   since_rst <= 0;
    else if (since_rst <= LAT) since_rst <= since_rst + 1;
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!valid_o && sum_o == '0));

  // R5: every strobe yields a pulse after the fixed latency
  a_r5_strobe_to_valid: assert property (@(posedge clk) disable iff (rst)
    (since_rst > LAT && $past(start_i, LAT)) |-> valid_o);

  // R5: no pulse without a strobe at the matching distance
  a_r5_valid_from_strobe: assert property (@(posedge clk) disable iff (rst)
    (valid_o && since_rst > LAT) |-> $past(start_i, LAT));

  // R6
  a_r6_hold_result: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(sum_o));

  // R4
  a_r4_zero_weights: assert property (@(posedge clk) disable iff (rst)
    (since_rst > LAT && $past(start_i && weights_i == '0, LAT)) |-> sum_o == '0);

endmodule

bind dotprod_pipe dotprod_pipe_chk #(
  .N_ELEM(N_ELEM), .DW(DW), .PW(PW), .LAT($clog2(N_ELEM) + 1)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .weights_i (weights_i),
  .valid_o   (valid_o),
  .sum_o     (sum_o)
);

// File: tb/dotprod_pipe_tb_top.sv
module dotprod_pipe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 26;
  localparam int DW  = 16;
  localparam int PW  = 32;
  localparam int LAT = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [N*DW-1:0] wbank = '0;
  logic [N*DW-1:0] abank = '0;
  logic            valid;
  logic [PW-1:0]   sum;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seed   = 32'h1234_5678;
  int wv [N];
  int av [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dotprod_pipe dut_i (
    .clk(clk), .rst(rst), .start_i(start),
    .weights_i(wbank), .acts_i(abank),
    .valid_o(valid), .sum_o(sum)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      report();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int rnd16(input int mask);
    int r;
    seed = seed * 1103515245 + 12345;
    r = (seed >>> 16) & mask;
    if (mask == 32'hffff && r > 32767) r = r - 65536;
    else if (mask != 32'hffff) r = r - (mask + 1) / 2;
    return r;
  endfunction

  function automatic logic [31:0] model();
    longint s = 0;
    for (int i = 0; i < N; i++) s += longint'(wv[i]) * longint'(av[i]);
    return s[31:0];
  endfunction

  task automatic pack();
    for (int i = 0; i < N; i++) begin
      wbank[i*DW +: DW] = wv[i][DW-1:0];
      abank[i*DW +: DW] = av[i][DW-1:0];
    end
  endtask

  task automatic clear_vecs();
    for (int i = 0; i < N; i++) begin
      wv[i] = 0;
      av[i] = 0;
    end
  endtask

  // Called at a negedge: strobe, then check latency, value and single pulse.
  task automatic run_one(input string req);
    logic [31:0] exp;
    exp = model();
    pack();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 no early valid", {31'd0, valid}, 32'd0);
    @(negedge clk);
    chk("R5 valid at latency", {31'd0, valid}, 32'd1);
    chk(req, sum, exp);
    @(negedge clk);
    chk("R5 single pulse", {31'd0, valid}, 32'd0);
  endtask

  initial begin
    logic [31:0] held;
    logic [31:0] exp3 [3];

    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 valid after reset", {31'd0, valid}, 32'd0);
    chk("R1 sum after reset", sum, 32'd0);
    @(negedge clk);

    // R9 / R2: single nonzero pair at each position
    for (int p = 0; p < N; p++) begin
      clear_vecs();
      wv[p] = p * 97 - 1200;
      av[p] = 500 - p * 61;
      run_one("R9 single position");
    end

    // R3: extreme products
    clear_vecs();
    wv[3] = -32768; av[3] = -32768;
    run_one("R3 min x min");
    chk("R3 min x min exact", sum, 32'h4000_0000);
    clear_vecs();
    wv[17] = -32768; av[17] = 32767;
    run_one("R3 min x max");

    // R4: wrap with all-min operands, and all-zero weights
    for (int i = 0; i < N; i++) begin wv[i] = -32768; av[i] = -32768; end
    run_one("R4 wrap modulo 2^32");
    chk("R4 wrap value", sum, 32'h8000_0000);
    for (int i = 0; i < N; i++) begin wv[i] = 0; av[i] = rnd16(32'hffff); end
    run_one("R4 zero weights");

    // R8: bias through slot 25
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < N - 1; i++) begin wv[i] = rnd16(32'h0fff); av[i] = rnd16(32'h0fff); end
      wv[N-1] = 1024;
      av[N-1] = (t == 0) ? -32768 : rnd16(32'hffff);
      run_one("R8 bias slot");
    end

    // R4 / R2: pseudo-random full vectors
    for (int t = 0; t < 20; t++) begin
      for (int i = 0; i < N; i++) begin wv[i] = rnd16(32'h0fff); av[i] = rnd16(32'h0fff); end
      run_one("R4 random vector");
    end

    // R6 / R10: bank changes without strobe are ignored, output held
    held = sum;
    for (int t = 0; t < 8; t++) begin
      for (int i = 0; i < N; i++) begin wv[i] = rnd16(32'hffff); av[i] = rnd16(32'hffff); end
      pack();
      @(negedge clk);
      chk("R10 no valid without strobe", {31'd0, valid}, 32'd0);
      chk("R6 sum held", sum, held);
    end

    // R7: three consecutive strobes
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < N; i++) begin wv[i] = rnd16(32'h0fff); av[i] = rnd16(32'h0fff); end
      exp3[k] = model();
      pack();
      start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R7 streamed valid", {31'd0, valid}, 32'd1);
      chk("R7 streamed result", sum, exp3[k]);
      @(negedge clk);
    end
    chk("R7 stream ends", {31'd0, valid}, 32'd0);
    chk("R6 last result held", sum, exp3[2]);

    report();
  end

endmodule